// File: doc/BRIEF.md
# Variable-Length Instruction Execution Core

This block is a multi-cycle execution engine for 64-bit instruction words held in a word-addressed memory. It keeps three architectural registers: a program counter (PC), an allocation pointer (AP) and a stack-frame pointer (SP). For each instruction it fetches the first word and decodes the packed control fields. It then forms three operand addresses (op0, op1 and dst), each one a base register plus a biased 16-bit offset. It reads the three operands and computes a result. Depending on the instruction, it may store the result at the dst address and write the two call-frame words. Finally it commits new PC, AP and SP values. Each register has its own update rule, selected by its own mode field.

An instruction is one or two words long. When op1 is addressed relative to PC, the instruction is two words long and the op1 address normally points at the word after it. Addition and multiplication are performed in the prime field of modulus 2^64 - 2^32 + 1. Multiplication runs bit-serially in a separate arithmetic unit that has a start/busy/done handshake.

A pulse on `start` loads the three registers from the init inputs and begins execution. A high `halt_req` makes the core stop once the current instruction has committed. An encoding that is not defined makes the core stop with `illegal` set, without changing any state.

Top module: `vlx_core`

## Requirements
- R1: After reset, `running` and `illegal` are 0, and `pc`, `ap` and `sp` are 0.
- R2: A `start` pulse while idle loads PC, AP and SP from `pc_init`, `ap_init` and `sp_init` on the next clock edge, raises `running` and clears `illegal`.
- R3: The first-word field positions are as follows. Bits 15:0 hold the op0 offset, 31:16 the op1 offset, 47:32 the dst offset and 48 the dummy flag. Bit 49 selects the dst base, 52:50 the op1 base and 53 the op0 base. Bits 57:54 hold the opcode, 60:58 the PC mode, 62:61 the AP mode and 63 the dst write enable. An effective address is the base plus the offset field minus 32768, computed modulo 2^64.
- R4: Opcode 0000 produces res = (op0 + op1) mod (2^64 - 2^32 + 1), with each operand reduced first.
- R5: Opcode 0001 produces res = (op0 * op1) mod (2^64 - 2^32 + 1).
- R6: Opcode 1000 (move) produces res = op1. When bit 63 is 1, res is stored at the dst address. When it is 0, memory is left unchanged.
- R7: The op1 base select takes 000 = PC, which also makes the instruction 2 words long; 001 = SP; 010 = AP; and 100 = the value read at op0. The op0 and dst base bits take 0 = SP and 1 = AP.
- R8: PC modes: 000 gives PC + size; 001 gives res; 010 gives PC + res; 100 gives PC + size when the dst value is 0, and PC + op1 otherwise.
- R9: AP modes: 00 keeps AP; 01 gives AP + 1; 10 gives AP + res (modulo 2^64).
- R10: Opcode 0010 (call) writes the old SP at address AP and the old PC at address AP + 1. It then sets AP and SP to the old AP + 2, and PC follows the PC mode with res = op1.
- R11: Opcode 0100 (return) loads SP with the value read at dst. PC follows the PC mode with res = op1.
- R12: Any of the following encodings stops the core with `illegal` = 1 and `running` = 0, leaves PC, AP, SP and memory unchanged, and performs no memory write: an unlisted opcode, PC mode, AP mode or op1 base select, or dummy bit = 1.
- R13: With `halt_req` high, the core completes the current instruction and then stops (`running` = 0). While stopped it issues no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load registers from the init inputs and begin execution |
| halt_req | input | 1 | Stop after the current instruction commits |
| pc_init | input | 64 | Initial PC |
| ap_init | input | 64 | Initial AP |
| sp_init | input | 64 | Initial SP |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable (qualified by mem_en) |
| mem_addr | output | 64 | Word address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read strobe |
| running | output | 1 | Core is executing |
| illegal | output | 1 | Last stop was caused by an undefined encoding |
| pc | output | 64 | Current PC |
| ap | output | 64 | Current AP |
| sp | output | 64 | Current SP |

## Verification
The bench targets a set of corner cases, each paired with the faulty behaviour it would expose:
- Field arithmetic with inputs at or above the modulus, and a product of (P-1)·(P-1). A missing pre-reduction or final conditional subtraction would return a wrong residue.
- An op1 address that wraps below zero through the bias. A design that drops the bias or truncates the address would read the wrong word.
- Immediate-form instructions under the fall-through and conditional PC modes, which catch a core that advances PC by 1 instead of 2.
- The op1 base taken from the op0 value, which exposes an address formed from a stale register.
- A call and a return, which check the frame word order and the old-AP-plus-two rule.
- Each class of undefined encoding, aimed at a core that leaves state changed or writes memory.
- A halt raised in mid-run, which must stop exactly one instruction later.

// File: rtl/vlx_core_pkg.sv
package vlx_core_pkg;

  localparam int INSN_W   = 64;
  localparam int OFF_W    = 16;
  localparam int OFF_BIAS = 1 << (OFF_W - 1);

  localparam logic [3:0] OPC_ADD  = 4'b0000;
  localparam logic [3:0] OPC_MUL  = 4'b0001;
  localparam logic [3:0] OPC_CALL = 4'b0010;
  localparam logic [3:0] OPC_RET  = 4'b0100;
  localparam logic [3:0] OPC_MOV  = 4'b1000;

  // Packed first instruction word, most significant field first.
  typedef struct packed {
    logic             dst_we;
    logic [1:0]       ap_mode;
    logic [2:0]       pc_mode;
    logic [3:0]       opcode;
    logic             op0_sel;
    logic [2:0]       op1_sel;
    logic             dst_sel;
    logic             dummy;
    logic [OFF_W-1:0] dst_off;
    logic [OFF_W-1:0] op1_off;
    logic [OFF_W-1:0] op0_off;
  } insn_t;

  typedef enum logic [1:0] {ALU_ADD, ALU_MUL, ALU_PASS} alu_op_e;

endpackage

// File: rtl/vlx_decode.sv
module vlx_decode
  import vlx_core_pkg::*;
(
  input  insn_t   ir,
  output logic    illegal,
  output logic    two_word,
  output alu_op_e alu_op,
  output logic    is_call,
  output logic    is_ret
);

  logic opc_ok, pcm_ok, apm_ok, op1_ok;

  always_comb begin
    opc_ok   = ir.opcode inside {OPC_ADD, OPC_MUL, OPC_CALL, OPC_RET, OPC_MOV};
    pcm_ok   = ir.pc_mode inside {3'b000, 3'b001, 3'b010, 3'b100};
    apm_ok   = ir.ap_mode != 2'b11;
    op1_ok   = ir.op1_sel inside {3'b000, 3'b001, 3'b010, 3'b100};
    illegal  = ir.dummy | ~opc_ok | ~pcm_ok | ~apm_ok | ~op1_ok;
    two_word = ir.op1_sel == 3'b000;
    is_call  = ir.opcode == OPC_CALL;
    is_ret   = ir.opcode == OPC_RET;
    case (ir.opcode)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_MUL: alu_op = ALU_MUL;
      default: alu_op = ALU_PASS;
    endcase
  end

endmodule

// File: rtl/vlx_field_alu.sv
module vlx_field_alu
  import vlx_core_pkg::*;
#(
  parameter int              XLEN    = 64,
  parameter logic [XLEN-1:0] MODULUS = 64'hFFFF_FFFF_0000_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] res
);

  localparam int CNT_W = $clog2(XLEN);

  logic [XLEN-1:0]  acc_q, acc_d, mcand_q, mcand_d, mplier_q, mplier_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, done_q, done_d;
  logic [XLEN-1:0]  step;

  function automatic logic [XLEN-1:0] reduce(input logic [XLEN-1:0] x);
    return (x >= MODULUS) ? x - MODULUS : x;
  endfunction

  // Both inputs below the modulus: one conditional subtraction suffices.
  function automatic logic [XLEN-1:0] modadd(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    logic [XLEN:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, MODULUS}) s = s - {1'b0, MODULUS};
    return s[XLEN-1:0];
  endfunction

  always_comb begin
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    cnt_d    = cnt_q;
    busy_d   = busy_q;
    done_d   = 1'b0;
    step     = modadd(acc_q, acc_q);
    if (mplier_q[XLEN-1]) step = modadd(step, mcand_q);
    if (start) begin
      case (op)
        ALU_ADD: begin acc_d = modadd(reduce(a), reduce(b)); done_d = 1'b1; end
        ALU_MUL: begin
          acc_d    = '0;
          mcand_d  = reduce(a);
          mplier_d = b;
          cnt_d    = CNT_W'(XLEN - 1);
          busy_d   = 1'b1;
        end
        default: begin acc_d = b; done_d = 1'b1; end
      endcase
    end else if (busy_q) begin
      acc_d    = step;
      mplier_d = mplier_q << 1;
      cnt_d    = cnt_q - 1'b1;
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      cnt_q    <= cnt_d;
      busy_q   <= busy_d;
      done_q   <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign res  = acc_q;

  assert_mul_goes_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == ALU_MUL) |=> (busy && !done));

  assert_add_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == ALU_ADD) |=> (done && !busy));

  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/vlx_core.sv
module vlx_core
  import vlx_core_pkg::*;
#(
  parameter int              XLEN    = 64,
  parameter logic [XLEN-1:0] MODULUS = 64'hFFFF_FFFF_0000_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            halt_req,
  input  logic [XLEN-1:0] pc_init,
  input  logic [XLEN-1:0] ap_init,
  input  logic [XLEN-1:0] sp_init,
  output logic            mem_en,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            running,
  output logic            illegal,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] ap,
  output logic [XLEN-1:0] sp
);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DEC, S_RD0, S_RD1, S_RDD,
    S_EXE, S_WAIT, S_WB, S_CALL0, S_CALL1, S_UPD
  } state_e;

  state_e          state_q, state_d;
  logic [XLEN-1:0] pc_q, pc_d, ap_q, ap_d, sp_q, sp_d;
  logic [XLEN-1:0] op0v_q, op0v_d, op1v_q, op1v_d, dstv_q, dstv_d, res_q, res_d;
  insn_t           ir_q, ir_d;
  logic            ill_q, ill_d;

  logic            dec_illegal, two_word, is_call, is_ret;
  alu_op_e         alu_op;
  logic            alu_start, alu_busy, alu_done;
  logic [XLEN-1:0] alu_res;
  logic [XLEN-1:0] size, op0_addr, op1_addr, dst_addr, op1_base;

  function automatic logic [XLEN-1:0] eff(input logic [XLEN-1:0] base, input logic [OFF_W-1:0] off);
    return base + XLEN'(off) - XLEN'(OFF_BIAS);
  endfunction

  vlx_decode u_dec (
    .ir       (ir_q),
    .illegal  (dec_illegal),
    .two_word (two_word),
    .alu_op   (alu_op),
    .is_call  (is_call),
    .is_ret   (is_ret)
  );

  vlx_field_alu #(.XLEN(XLEN), .MODULUS(MODULUS)) u_alu (
    .clk   (clk),
    .rst_n (rst_n),
    .start (alu_start),
    .op    (alu_op),
    .a     (op0v_q),
    .b     (op1v_q),
    .busy  (alu_busy),
    .done  (alu_done),
    .res   (alu_res)
  );

  // Operand addressing; op1 may be based on the op0 value arriving this cycle.
  always_comb begin
    size = two_word ? XLEN'(2) : XLEN'(1);
    case (ir_q.op1_sel)
      3'b000:  op1_base = pc_q;
      3'b001:  op1_base = sp_q;
      3'b010:  op1_base = ap_q;
      default: op1_base = mem_rdata;
    endcase
    op0_addr = eff(ir_q.op0_sel ? ap_q : sp_q, ir_q.op0_off);
    op1_addr = eff(op1_base, ir_q.op1_off);
    dst_addr = eff(ir_q.dst_sel ? ap_q : sp_q, ir_q.dst_off);
  end

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    ap_d      = ap_q;
    sp_d      = sp_q;
    ir_d      = ir_q;
    op0v_d    = op0v_q;
    op1v_d    = op1v_q;
    dstv_d    = dstv_q;
    res_d     = res_q;
    ill_d     = ill_q;
    alu_start = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = res_q;
    case (state_q)
      S_IDLE: if (start) begin
        pc_d = pc_init; ap_d = ap_init; sp_d = sp_init;
        ill_d = 1'b0; state_d = S_FETCH;
      end
      S_FETCH: begin mem_en = 1'b1; state_d = S_DEC; end
      S_DEC:   begin ir_d = insn_t'(mem_rdata[INSN_W-1:0]); state_d = S_RD0; end
      S_RD0: begin
        if (dec_illegal) begin
          ill_d = 1'b1; state_d = S_IDLE;
        end else begin
          mem_en = 1'b1; mem_addr = op0_addr; state_d = S_RD1;
        end
      end
      S_RD1: begin op0v_d = mem_rdata; mem_en = 1'b1; mem_addr = op1_addr; state_d = S_RDD; end
      S_RDD: begin op1v_d = mem_rdata; mem_en = 1'b1; mem_addr = dst_addr; state_d = S_EXE; end
      S_EXE: begin dstv_d = mem_rdata; alu_start = 1'b1; state_d = S_WAIT; end
      S_WAIT: if (alu_done) begin res_d = alu_res; state_d = S_WB; end
      S_WB: begin
        if (ir_q.dst_we) begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = dst_addr; end
        state_d = is_call ? S_CALL0 : S_UPD;
      end
      S_CALL0: begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = ap_q; mem_wdata = sp_q; state_d = S_CALL1; end
      S_CALL1: begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = ap_q + 1'b1; mem_wdata = pc_q; state_d = S_UPD; end
      S_UPD: begin
        case (ir_q.pc_mode)
          3'b001:  pc_d = res_q;
          3'b010:  pc_d = pc_q + res_q;
          3'b100:  pc_d = (dstv_q == '0) ? pc_q + size : pc_q + op1v_q;
          default: pc_d = pc_q + size;
        endcase
        if (is_call) begin
          ap_d = ap_q + XLEN'(2);
          sp_d = ap_q + XLEN'(2);
        end else begin
          case (ir_q.ap_mode)
            2'b01:   ap_d = ap_q + 1'b1;
            2'b10:   ap_d = ap_q + res_q;
            default: ap_d = ap_q;
          endcase
          if (is_ret) sp_d = dstv_q;
        end
        state_d = halt_req ? S_IDLE : S_FETCH;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      ap_q    <= '0;
      sp_q    <= '0;
      ir_q    <= '0;
      op0v_q  <= '0;
      op1v_q  <= '0;
      dstv_q  <= '0;
      res_q   <= '0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ap_q    <= ap_d;
      sp_q    <= sp_d;
      ir_q    <= ir_d;
      op0v_q  <= op0v_d;
      op1v_q  <= op1v_d;
      dstv_q  <= dstv_d;
      res_q   <= res_d;
      ill_q   <= ill_d;
    end
  end

  assign running = state_q != S_IDLE;
  assign illegal = ill_q;
  assign pc      = pc_q;
  assign ap      = ap_q;
  assign sp      = sp_q;

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start) |=>
      (running && !illegal && pc_q == $past(pc_init) && ap_q == $past(ap_init) && sp_q == $past(sp_init)));

  assert_illegal_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !running);

  assert_illegal_no_effect_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RD0 && dec_illegal) |=> ($stable(pc_q) && $stable(ap_q) && $stable(sp_q) && !mem_en));

  assert_call_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_UPD && is_call) |=> (ap_q == sp_q && ap_q == $past(ap_q) + XLEN'(2)));

  assert_ap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_UPD && !is_call && ir_q.ap_mode == 2'b00) |=> $stable(ap_q));

  assert_stopped_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !mem_en);

endmodule

// File: tb/vlx_core_tb.sv
module vlx_core_tb_top;

  localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;

  logic        clk, rst_n, start, halt_req;
  logic [63:0] pc_init, ap_init, sp_init;
  logic        mem_en, mem_we;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic        running, illegal;
  logic [63:0] pc, ap, sp;

  logic [63:0] mem [256];
  int checks = 0;
  int fails  = 0;

  vlx_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .halt_req(halt_req),
    .pc_init(pc_init), .ap_init(ap_init), .sp_init(sp_init),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .running(running), .illegal(illegal), .pc(pc), .ap(ap), .sp(sp)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  function automatic logic [63:0] enc(input bit dw, input logic [1:0] apm, input logic [2:0] pcm,
                                      input logic [3:0] opc, input bit s0, input logic [2:0] s1,
                                      input bit sd, input int d0, input int d1, input int dd);
    return {dw, apm, pcm, opc, s0, s1, sd, 1'b0, 16'(dd + 32768), 16'(d1 + 32768), 16'(d0 + 32768)};
  endfunction

  function automatic logic [63:0] fadd(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] t;
    t = (128'(a) % 128'(P)) + (128'(b) % 128'(P));
    return 64'(t % 128'(P));
  endfunction

  function automatic logic [63:0] fmul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] t;
    t = 128'(a) * 128'(b);
    return 64'(t % 128'(P));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] v);
    mem[a] <= v;
  endtask

  task automatic run_insn(input logic [63:0] p, input logic [63:0] a, input logic [63:0] s);
    pc_init = p; ap_init = a; sp_init = s;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 400 && running; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 running", 64'(running), 64'd0);
    chk("R1 illegal", 64'(illegal), 64'd0);
    chk("R1 pc", pc, 64'd0);
    chk("R1 ap", ap, 64'd0);
    chk("R1 sp", sp, 64'd0);
  endtask

  task automatic t_add(input logic [63:0] a, input logic [63:0] b);
    wr(0, enc(1, 2'b01, 3'b000, 4'b0000, 1, 3'b010, 1, 0, 1, 2));
    wr(100, a); wr(101, b); wr(102, 64'h0);
    run_insn(64'd0, 64'd100, 64'd50);
    chk("R4 add result", mem[102], fadd(a, b));
    chk("R8 fall-through pc", pc, 64'd1);
    chk("R9 ap plus one", ap, 64'd101);
    chk("R3 sp unchanged", sp, 64'd50);
  endtask

  task automatic t_mul(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    r = fmul(a, b);
    wr(20, enc(1, 2'b10, 3'b000, 4'b0001, 0, 3'b000, 0, 3, 1, 5));
    wr(21, b); wr(53, a); wr(55, 64'h0);
    run_insn(64'd20, 64'd100, 64'd50);
    chk("R5 mul result", mem[55], r);
    chk("R7 immediate size pc", pc, 64'd22);
    chk("R9 ap plus res", ap, 64'd100 + r);
  endtask

  task automatic t_mov_indirect;
    wr(5, enc(0, 2'b00, 3'b001, 4'b1000, 1, 3'b100, 1, 0, 2, 1));
    wr(100, 64'd150); wr(152, 64'h77); wr(101, 64'hABCD);
    run_insn(64'd5, 64'd100, 64'd50);
    chk("R7 op0-based op1 / R8 absolute pc", pc, 64'h77);
    chk("R6 no write when bit63=0", mem[101], 64'hABCD);
    chk("R9 ap kept", ap, 64'd100);
  endtask

  task automatic t_wrap;
    wr(0, enc(1, 2'b00, 3'b000, 4'b1000, 0, 3'b001, 1, 0, -3, 7));
    wr(255, 64'h5A5A); wr(207, 64'h0);
    run_insn(64'd0, 64'd200, 64'd2);
    chk("R3 wrapped op1 address / R6 move write", mem[207], 64'h5A5A);
    chk("R3 pc", pc, 64'd1);
  endtask

  task automatic t_rel;
    wr(30, enc(0, 2'b00, 3'b010, 4'b1000, 1, 3'b010, 1, 0, 0, 0));
    wr(100, 64'd7);
    run_insn(64'd30, 64'd100, 64'd50);
    chk("R8 relative pc", pc, 64'd37);
  endtask

  task automatic t_cond(input logic [63:0] dv, input logic [63:0] exp_pc);
    wr(40, enc(0, 2'b00, 3'b100, 4'b1000, 1, 3'b000, 1, 0, 1, 1));
    wr(41, 64'd12); wr(101, dv);
    run_insn(64'd40, 64'd100, 64'd50);
    chk("R8 conditional pc", pc, exp_pc);
  endtask

  task automatic t_call;
    wr(60, enc(0, 2'b00, 3'b010, 4'b0010, 1, 3'b000, 1, 0, 1, 0));
    wr(61, 64'd16); wr(100, 64'h0); wr(101, 64'h0);
    run_insn(64'd60, 64'd100, 64'd40);
    chk("R10 saved sp", mem[100], 64'd40);
    chk("R10 saved pc", mem[101], 64'd60);
    chk("R10 ap", ap, 64'd102);
    chk("R10 sp", sp, 64'd102);
    chk("R10 pc", pc, 64'd76);
  endtask

  task automatic t_ret;
    wr(70, enc(0, 2'b00, 3'b001, 4'b0100, 1, 3'b010, 0, 0, -1, -2));
    wr(119, 64'h61); wr(100, 64'd40);
    run_insn(64'd70, 64'd120, 64'd102);
    chk("R11 sp from dst", sp, 64'd40);
    chk("R11 pc", pc, 64'h61);
    chk("R11 ap", ap, 64'd120);
  endtask

  task automatic t_illegal(input logic [63:0] w, input string what);
    wr(90, w); wr(100, 64'h1111);
    run_insn(64'd90, 64'd100, 64'd50);
    chk({"R12 illegal flag ", what}, 64'(illegal), 64'd1);
    chk({"R12 stopped ", what}, 64'(running), 64'd0);
    chk({"R12 pc kept ", what}, pc, 64'd90);
    chk({"R12 ap kept ", what}, ap, 64'd100);
    chk({"R12 no write ", what}, mem[100], 64'h1111);
  endtask

  task automatic t_halt;
    for (int i = 8; i < 14; i++) wr(i, enc(0, 2'b01, 3'b000, 4'b1000, 1, 3'b010, 1, 0, 0, 0));
    halt_req = 1'b0;
    pc_init = 64'd8; ap_init = 64'd100; sp_init = 64'd50;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 pc loaded", pc, 64'd8);
    chk("R2 running", 64'(running), 64'd1);
    chk("R2 illegal cleared", 64'(illegal), 64'd0);
    for (int i = 0; i < 400 && pc != 64'd10; i++) @(negedge clk);
    halt_req = 1'b1;
    for (int i = 0; i < 400 && running; i++) @(negedge clk);
    chk("R13 stopped", 64'(running), 64'd0);
    chk("R13 pc after halt", pc, 64'd11);
    chk("R13 ap after halt", ap, 64'd103);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; halt_req = 1'b1;
    pc_init = '0; ap_init = '0; sp_init = '0;
    for (int i = 0; i < 256; i++) mem[i] <= 64'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add(P - 64'd1, 64'd5);
    t_add(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0);
    t_mul(P - 64'd1, P - 64'd1);
    t_mul(64'h8000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0);
    t_mov_indirect();
    t_wrap();
    t_rel();
    t_cond(64'd0, 64'd42);
    t_cond(64'd5, 64'd52);
    t_call();
    t_ret();
    t_illegal(enc(1, 2'b00, 3'b000, 4'b0011, 1, 3'b010, 1, 0, 0, 0), "opcode");
    t_illegal(enc(1, 2'b00, 3'b011, 4'b0000, 1, 3'b010, 1, 0, 0, 0), "pc mode");
    t_illegal(enc(1, 2'b11, 3'b000, 4'b0000, 1, 3'b010, 1, 0, 0, 0), "ap mode");
    t_illegal(enc(1, 2'b00, 3'b000, 4'b0000, 1, 3'b011, 1, 0, 0, 0), "op1 base");
    t_illegal(enc(1, 2'b00, 3'b000, 4'b0000, 1, 3'b010, 1, 0, 0, 0) | (64'd1 << 48), "dummy");
    t_halt();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule